// File: doc/BRIEF.md
# Genetic Grid Cell Generation Controller

This block is a single node of a two-dimensional array of genetic-algorithm cells. Each cell keeps one chromosome, which is an ordered list of request genes. For a scheduling problem the order of the genes is the order of service. Lower fitness is better. The cell exports its chromosome and its fitness all the time so that the cells next to it can read them.

When `start` arrives, the cell takes the neighbour (north, south, east or west) that reports the smallest fitness as its mate. It copies its own chromosome into a first-parent register and the mate into a second-parent register. It then asks an external crossover engine for two children. An external fitness evaluator, shared by all three candidates, scores the parent, child one and child two in turn. The best of the three replaces the stored chromosome. If the mutation enable was asserted with `start`, the genes at two given positions of that survivor are exchanged before it is stored. One generation ends with a single-cycle `gen_done` pulse.

The crossover and fitness engines are reached through request/acknowledge ports. Random positions and the mutation decision come from outside the cell. Driving the array and counting generations belong to the level above.

Top module: `gacell_ctrl`

## Requirements
- R1: At `start` the second-parent output `xo_p2` carries the neighbour chromosome whose fitness is smallest. Neighbour slot 0 is north, 1 is south, 2 is east and 3 is west. Equal fitness goes to the lower slot. `xo_p1` carries the cell's own chromosome.
- R2: `xo_req` stays high, with steady parents, until `xo_ack`. The children present with `xo_ack` are captured.
- R3: The fitness port is asked three times, one request at a time, in the order parent, child one, child two. Each request holds until `fit_ack`. `xo_req` and `fit_req` are never high together.
- R4: The new chromosome is the candidate with the smallest fitness. Ties favour the parent, then child one. `cur_fit` becomes that candidate's fitness.
- R5: If `mut_en` was high with `start`, genes `mut_pos_a` and `mut_pos_b` of the survivor are exchanged. Gene i occupies bits [i*GENE_W +: GENE_W].
- R6: When the two mutation positions are equal, the survivor is stored unchanged.
- R7: `gen_done` is high for exactly one cycle, in the cycle after the survivor is written.
- R8: While a generation is in progress, up to and including the `gen_done` cycle, `start` has no effect.
- R9: After reset `cur_chrom` is zero, `cur_fit` is all ones, and no request or done signal is high.
- R10: `load_en` in the idle state stores `load_chrom` and sets `cur_fit` to all ones. It takes priority over `start` and is ignored during a generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_chrom` into the cell (idle only) |
| load_chrom | input | GENES*GENE_W | Chromosome to load |
| start | input | 1 | Begin one generation |
| mut_en | input | 1 | Mutate the survivor of this generation |
| mut_pos_a | input | $clog2(GENES) | First mutation position |
| mut_pos_b | input | $clog2(GENES) | Second mutation position |
| nbr_fit | input | 4*FIT_W | Neighbour fitness values, slots N,S,E,W |
| nbr_chrom | input | 4*GENES*GENE_W | Neighbour chromosomes, same slots |
| xo_req | output | 1 | Crossover request |
| xo_p1 | output | GENES*GENE_W | First parent |
| xo_p2 | output | GENES*GENE_W | Second parent (mate) |
| xo_ack | input | 1 | Crossover result valid |
| xo_child1 | input | GENES*GENE_W | First child |
| xo_child2 | input | GENES*GENE_W | Second child |
| fit_req | output | 1 | Fitness evaluation request |
| fit_chrom | output | GENES*GENE_W | Chromosome to evaluate |
| fit_ack | input | 1 | Fitness result valid |
| fit_val | input | FIT_W | Fitness result |
| gen_done | output | 1 | Generation finished pulse |
| cur_chrom | output | GENES*GENE_W | Stored chromosome |
| cur_fit | output | FIT_W | Fitness of the stored chromosome |

## Verification
The assertions assume that each engine raises its acknowledge only while the matching request is high, and that the result data is valid in that acknowledge cycle. They also assume that the mutation positions are below GENES and that the neighbour inputs settle before the `start` edge. The bench responders meet these assumptions. They answer every request on the cycle after it appears, compute fitness as the sum of absolute differences between consecutive genes, and hold their acknowledges for one cycle only. The directed tasks change the neighbour values only while the cell is idle.

// File: rtl/gacell_pkg.sv
package gacell_pkg;

    // neighbour slot order; also the tie-break priority for mate choice
    localparam int NBR_N    = 0;
    localparam int NBR_S    = 1;
    localparam int NBR_E    = 2;
    localparam int NBR_W    = 3;
    localparam int NBR_CNT  = 4;

    // candidate order; also the tie-break priority for survivor choice
    localparam int CAND_PAR = 0;
    localparam int CAND_C1  = 1;
    localparam int CAND_C2  = 2;
    localparam int CAND_CNT = 3;

    localparam int MUT_POS_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XO,
        ST_FIT,
        ST_SEL,
        ST_DONE
    } gstate_t;

    typedef struct packed {
        logic                 en;
        logic [MUT_POS_W-1:0] a;
        logic [MUT_POS_W-1:0] b;
    } mut_req_t;

    function automatic mut_req_t make_mut(input logic en,
                                          input logic [MUT_POS_W-1:0] a,
                                          input logic [MUT_POS_W-1:0] b);
        mut_req_t r;
        r.en = en;
        r.a  = a;
        r.b  = b;
        return r;
    endfunction

endpackage

// File: rtl/gacell_min_pick.sv
module gacell_min_pick #(
    parameter int N  = 4,
    parameter int W  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*W-1:0] vals,
    output logic [IW-1:0]  idx,
    output logic [W-1:0]   val
);
    // strict less-than keeps the lowest slot on equal values
    always_comb begin
        val = vals[W-1:0];
        idx = '0;
        for (int i = 1; i < N; i++) begin
            if (vals[i*W +: W] < val) begin
                val = vals[i*W +: W];
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/gacell_swap_mut.sv
module gacell_swap_mut #(
    parameter int GENES  = 32,
    parameter int GENE_W = 24,
    parameter int PW     = $clog2(GENES)
) (
    input  logic [GENES*GENE_W-1:0] chrom_in,
    input  logic                    en,
    input  logic [PW-1:0]           pos_a,
    input  logic [PW-1:0]           pos_b,
    output logic [GENES*GENE_W-1:0] chrom_out
);
    logic [GENE_W-1:0] gene_a;
    logic [GENE_W-1:0] gene_b;

    always_comb begin
        gene_a    = chrom_in[pos_a*GENE_W +: GENE_W];
        gene_b    = chrom_in[pos_b*GENE_W +: GENE_W];
        chrom_out = chrom_in;
        if (en) begin
            chrom_out[pos_a*GENE_W +: GENE_W] = gene_b;
            chrom_out[pos_b*GENE_W +: GENE_W] = gene_a;
        end
    end
endmodule

// File: rtl/gacell_ctrl.sv
module gacell_ctrl
    import gacell_pkg::*;
#(
    parameter int GENES  = 32,
    parameter int GENE_W = 24,
    parameter int FIT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_en,
    input  logic [GENES*GENE_W-1:0]       load_chrom,
    input  logic                          start,
    input  logic                          mut_en,
    input  logic [$clog2(GENES)-1:0]      mut_pos_a,
    input  logic [$clog2(GENES)-1:0]      mut_pos_b,
    input  logic [4*FIT_W-1:0]            nbr_fit,
    input  logic [4*GENES*GENE_W-1:0]     nbr_chrom,
    output logic                          xo_req,
    output logic [GENES*GENE_W-1:0]       xo_p1,
    output logic [GENES*GENE_W-1:0]       xo_p2,
    input  logic                          xo_ack,
    input  logic [GENES*GENE_W-1:0]       xo_child1,
    input  logic [GENES*GENE_W-1:0]       xo_child2,
    output logic                          fit_req,
    output logic [GENES*GENE_W-1:0]       fit_chrom,
    input  logic                          fit_ack,
    input  logic [FIT_W-1:0]              fit_val,
    output logic                          gen_done,
    output logic [GENES*GENE_W-1:0]       cur_chrom,
    output logic [FIT_W-1:0]              cur_fit
);
    localparam int CW      = GENES * GENE_W;
    localparam int PW      = $clog2(GENES);
    localparam int NIW     = $clog2(NBR_CNT);
    localparam int CIW     = $clog2(CAND_CNT);
    localparam int LAST_CI = CAND_CNT - 1;

    gstate_t                 st_q;
    logic [CW-1:0]           cur_q;
    logic [FIT_W-1:0]        cfit_q;
    logic [CW-1:0]           p1_q;
    logic [CW-1:0]           p2_q;
    logic [CW-1:0]           c1_q;
    logic [CW-1:0]           c2_q;
    logic [CAND_CNT*FIT_W-1:0] fit_q;
    logic [CIW-1:0]          fidx_q;
    mut_req_t                mut_q;

    // mate selection over the four neighbours
    logic [NIW-1:0]          mate_idx;
    logic [FIT_W-1:0]        mate_fit;
    logic [CW-1:0]           mate_chrom;

    gacell_min_pick #(.N(NBR_CNT), .W(FIT_W)) u_mate_pick (
        .vals (nbr_fit),
        .idx  (mate_idx),
        .val  (mate_fit)
    );

    assign mate_chrom = nbr_chrom[mate_idx*CW +: CW];

    // survivor selection over parent and two children
    logic [CIW-1:0]          surv_idx;
    logic [FIT_W-1:0]        surv_fit;
    logic [CW-1:0]           surv_chrom;
    logic [CW-1:0]           mut_chrom;

    gacell_min_pick #(.N(CAND_CNT), .W(FIT_W)) u_surv_pick (
        .vals (fit_q),
        .idx  (surv_idx),
        .val  (surv_fit)
    );

    always_comb begin
        case (surv_idx)
            CIW'(CAND_PAR): surv_chrom = cur_q;
            CIW'(CAND_C1):  surv_chrom = c1_q;
            default:        surv_chrom = c2_q;
        endcase
    end

    gacell_swap_mut #(.GENES(GENES), .GENE_W(GENE_W)) u_swap (
        .chrom_in  (surv_chrom),
        .en        (mut_q.en),
        .pos_a     (mut_q.a[PW-1:0]),
        .pos_b     (mut_q.b[PW-1:0]),
        .chrom_out (mut_chrom)
    );

    // shared fitness path: candidate picked by the evaluation index
    always_comb begin
        case (fidx_q)
            CIW'(CAND_PAR): fit_chrom = cur_q;
            CIW'(CAND_C1):  fit_chrom = c1_q;
            default:        fit_chrom = c2_q;
        endcase
    end

    // generation sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            cfit_q <= '1;
            p1_q   <= '0;
            p2_q   <= '0;
            c1_q   <= '0;
            c2_q   <= '0;
            fit_q  <= '1;
            fidx_q <= '0;
            mut_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (load_en) begin
                        cur_q  <= load_chrom;
                        cfit_q <= '1;
                    end else if (start) begin
                        p1_q  <= cur_q;
                        p2_q  <= mate_chrom;
                        mut_q <= make_mut(mut_en, MUT_POS_W'(mut_pos_a),
                                          MUT_POS_W'(mut_pos_b));
                        st_q  <= ST_XO;
                    end
                end
                ST_XO: begin
                    if (xo_ack) begin
                        c1_q   <= xo_child1;
                        c2_q   <= xo_child2;
                        fidx_q <= '0;
                        st_q   <= ST_FIT;
                    end
                end
                ST_FIT: begin
                    if (fit_ack) begin
                        fit_q[fidx_q*FIT_W +: FIT_W] <= fit_val;
                        if (fidx_q == CIW'(LAST_CI)) begin
                            st_q <= ST_SEL;
                        end else begin
                            fidx_q <= fidx_q + 1'b1;
                        end
                    end
                end
                ST_SEL: begin
                    cur_q  <= mut_chrom;
                    cfit_q <= surv_fit;
                    st_q   <= ST_DONE;
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign xo_req    = (st_q == ST_XO);
    assign xo_p1     = p1_q;
    assign xo_p2     = p2_q;
    assign fit_req   = (st_q == ST_FIT);
    assign gen_done  = (st_q == ST_DONE);
    assign cur_chrom = cur_q;
    assign cur_fit   = cfit_q;

    // ---------------- assertions ----------------
    for (genvar g = 0; g < NBR_CNT; g++) begin : g_mate_chk
        assert_mate_min_R1: assert property (@(posedge clk) disable iff (rst)
            (st_q == ST_IDLE && start && !load_en)
                |-> mate_fit <= nbr_fit[g*FIT_W +: FIT_W])
            else $error("mate fitness above neighbour %0d", g);
    end

    assert_xo_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (xo_req && !xo_ack) |=> (xo_req && $stable(xo_p1) && $stable(xo_p2)))
        else $error("crossover request dropped before ack");

    assert_fit_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (fit_req && !fit_ack) |=> (fit_req && $stable(fit_chrom)))
        else $error("fitness request dropped before ack");

    assert_one_req_R3: assert property (@(posedge clk) disable iff (rst)
        !(xo_req && fit_req))
        else $error("both engine requests active");

    for (genvar c = 0; c < CAND_CNT; c++) begin : g_surv_chk
        assert_surv_min_R4: assert property (@(posedge clk) disable iff (rst)
            (st_q == ST_SEL) |=> cur_fit <= $past(fit_q[c*FIT_W +: FIT_W]))
            else $error("survivor fitness above candidate %0d", c);
    end

    assert_same_pos_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SEL && mut_q.en && mut_q.a == mut_q.b)
            |=> cur_chrom == $past(surv_chrom))
        else $error("equal-position mutation altered chromosome");

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        gen_done |=> !gen_done)
        else $error("done held longer than one cycle");

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        gen_done |=> (!xo_req && !fit_req))
        else $error("new generation began from the done cycle");

endmodule

// File: tb/gacell_ctrl_tb_top.sv
module gacell_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GENES  = 32;
    localparam int GENE_W = 24;
    localparam int FIT_W  = 16;
    localparam int CW     = GENES * GENE_W;
    localparam int PW     = $clog2(GENES);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_en = 1'b0;
    logic [CW-1:0] load_chrom = '0;
    logic start = 1'b0;
    logic mut_en = 1'b0;
    logic [PW-1:0] mut_pos_a = '0;
    logic [PW-1:0] mut_pos_b = '0;
    logic [CW-1:0] nb [0:3];
    logic [FIT_W-1:0] nf [0:3];
    logic [4*FIT_W-1:0] nbr_fit;
    logic [4*CW-1:0] nbr_chrom;
    logic xo_req, fit_req, gen_done;
    logic [CW-1:0] xo_p1, xo_p2, fit_chrom, cur_chrom;
    logic [FIT_W-1:0] cur_fit;
    logic xo_ack = 1'b0;
    logic fit_ack = 1'b0;
    logic [CW-1:0] xo_child1 = '0;
    logic [CW-1:0] xo_child2 = '0;
    logic [FIT_W-1:0] fit_val = '0;

    logic [CW-1:0] tc1, tc2, rec_p1, rec_p2;
    logic [CW-1:0] rec_fc [0:3];
    int nfit;
    int n_chk = 0;
    int n_fail = 0;

    assign nbr_fit   = {nf[3], nf[2], nf[1], nf[0]};
    assign nbr_chrom = {nb[3], nb[2], nb[1], nb[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    gacell_ctrl #(.GENES(GENES), .GENE_W(GENE_W), .FIT_W(FIT_W)) dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_chrom(load_chrom),
        .start(start), .mut_en(mut_en), .mut_pos_a(mut_pos_a), .mut_pos_b(mut_pos_b),
        .nbr_fit(nbr_fit), .nbr_chrom(nbr_chrom),
        .xo_req(xo_req), .xo_p1(xo_p1), .xo_p2(xo_p2), .xo_ack(xo_ack),
        .xo_child1(xo_child1), .xo_child2(xo_child2),
        .fit_req(fit_req), .fit_chrom(fit_chrom), .fit_ack(fit_ack), .fit_val(fit_val),
        .gen_done(gen_done), .cur_chrom(cur_chrom), .cur_fit(cur_fit)
    );

    // ---------- chromosome helpers ----------
    function automatic logic [CW-1:0] mk_seq(input int base, input int step);
        logic [CW-1:0] c;
        for (int i = 0; i < GENES; i++) c[i*GENE_W +: GENE_W] = GENE_W'(base + i*step);
        return c;
    endfunction

    function automatic logic [CW-1:0] swapg(input logic [CW-1:0] c, input int a, input int b);
        logic [CW-1:0] r = c;
        r[a*GENE_W +: GENE_W] = c[b*GENE_W +: GENE_W];
        r[b*GENE_W +: GENE_W] = c[a*GENE_W +: GENE_W];
        return r;
    endfunction

    function automatic logic [CW-1:0] revg(input logic [CW-1:0] c);
        logic [CW-1:0] r;
        for (int i = 0; i < GENES; i++) r[i*GENE_W +: GENE_W] = c[(GENES-1-i)*GENE_W +: GENE_W];
        return r;
    endfunction

    function automatic logic [CW-1:0] rotg(input logic [CW-1:0] c, input int k);
        logic [CW-1:0] r;
        for (int i = 0; i < GENES; i++) r[i*GENE_W +: GENE_W] = c[((i+k)%GENES)*GENE_W +: GENE_W];
        return r;
    endfunction

    // seek-distance style fitness: sum of |g[i]-g[i+1]|
    function automatic logic [FIT_W-1:0] fitfn(input logic [CW-1:0] c);
        int s = 0;
        for (int i = 0; i < GENES-1; i++) begin
            int a = int'(c[i*GENE_W +: GENE_W]);
            int b = int'(c[(i+1)*GENE_W +: GENE_W]);
            s += (a > b) ? (a - b) : (b - a);
        end
        return FIT_W'(s);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------- engine responders ----------
    initial begin
        forever begin
            @(negedge clk);
            xo_ack = xo_req && !xo_ack;
            if (xo_ack) begin
                xo_child1 = tc1;
                xo_child2 = tc2;
                rec_p1 = xo_p1;
                rec_p2 = xo_p2;
            end
            fit_ack = fit_req && !fit_ack;
            if (fit_ack) begin
                fit_val = fitfn(fit_chrom);
                if (nfit < 4) rec_fc[nfit] = fit_chrom;
                nfit++;
            end
        end
    end

    // ---------- scenario tasks ----------
    task automatic do_reset_check();
        chk(cur_chrom == '0, "R9", "cur_chrom after reset", cur_chrom, '0);
        chk(cur_fit == '1, "R9", "cur_fit after reset", CW'(cur_fit), CW'(16'hFFFF));
        chk(!xo_req && !fit_req && !gen_done, "R9", "req/done after reset",
            CW'({xo_req, fit_req, gen_done}), '0);
    endtask

    task automatic do_load(input logic [CW-1:0] c);
        @(negedge clk);
        load_en = 1'b1;
        load_chrom = c;
        @(negedge clk);
        load_en = 1'b0;
        chk(cur_chrom == c, "R10", "loaded chromosome", cur_chrom, c);
        chk(cur_fit == '1, "R10", "fitness after load", CW'(cur_fit), CW'(16'hFFFF));
    endtask

    task automatic set_nbr(input int f0, input int f1, input int f2, input int f3);
        @(negedge clk);
        nf[0] = FIT_W'(f0); nf[1] = FIT_W'(f1); nf[2] = FIT_W'(f2); nf[3] = FIT_W'(f3);
        for (int i = 0; i < 4; i++) nb[i] = rotg(mk_seq(500 + 40*i, 7), 3*i + 1);
    endtask

    task automatic run_gen(input string req, input logic [CW-1:0] c1, input logic [CW-1:0] c2,
                           input bit m, input int pa, input int pb, input bit disturb);
        logic [CW-1:0] pre, surv, expc;
        logic [FIT_W-1:0] fv [0:2];
        int mi, si, waitc;
        pre = cur_chrom;
        tc1 = c1;
        tc2 = c2;
        mi = 0;
        for (int i = 1; i < 4; i++) if (nf[i] < nf[mi]) mi = i;
        @(negedge clk);
        nfit = 0;
        start = 1'b1; mut_en = m; mut_pos_a = PW'(pa); mut_pos_b = PW'(pb);
        @(negedge clk);
        start = 1'b0; mut_en = 1'b0;
        if (disturb) begin
            start = 1'b1; load_en = 1'b1; load_chrom = ~pre;
        end
        @(negedge clk);
        start = 1'b0; load_en = 1'b0;
        waitc = 0;
        while (!gen_done && waitc < 60) begin
            @(negedge clk);
            waitc++;
        end
        chk(gen_done, "R7", "done reached", CW'(gen_done), CW'(1));
        chk(rec_p1 == pre, "R1", "parent one is own chromosome", rec_p1, pre);
        chk(rec_p2 == nb[mi], "R1", "mate is lowest-fitness neighbour", rec_p2, nb[mi]);
        chk(nfit == 3, "R3", "three fitness requests", CW'(nfit), CW'(3));
        chk(rec_fc[0] == pre, "R3", "first evaluation is parent", rec_fc[0], pre);
        chk(rec_fc[1] == c1, "R3", "second evaluation is child one", rec_fc[1], c1);
        chk(rec_fc[2] == c2, "R3", "third evaluation is child two", rec_fc[2], c2);
        fv[0] = fitfn(pre); fv[1] = fitfn(c1); fv[2] = fitfn(c2);
        si = 0;
        if (fv[1] < fv[si]) si = 1;
        if (fv[2] < fv[si]) si = 2;
        surv = (si == 0) ? pre : (si == 1) ? c1 : c2;
        expc = m ? swapg(surv, pa, pb) : surv;
        chk(cur_chrom == expc, req, "stored survivor", cur_chrom, expc);
        chk(cur_fit == fv[si], "R4", "exported fitness", CW'(cur_fit), CW'(fv[si]));
        @(negedge clk);
        chk(!gen_done, "R7", "done drops after one cycle", CW'(gen_done), '0);
        if (disturb) begin
            for (int k = 0; k < 3; k++) begin
                chk(!xo_req, "R8", "no generation from ignored start", CW'(xo_req), '0);
                @(negedge clk);
            end
            chk(cur_chrom == expc, "R10", "load during generation ignored", cur_chrom, expc);
        end
    endtask

    // ---------- watchdog ----------
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------- main sequence ----------
    initial begin
        logic [CW-1:0] a, b;
        for (int i = 0; i < 4; i++) begin nb[i] = '0; nf[i] = '1; end
        tc1 = '0; tc2 = '0; rec_p1 = '0; rec_p2 = '0; nfit = 0;
        for (int i = 0; i < 4; i++) rec_fc[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        do_reset_check();

        a = swapg(mk_seq(100, 3), 0, 31);
        do_load(a);

        // child one improves on the parent; clear mate (south)
        set_nbr(50, 20, 30, 40);
        run_gen("R4", mk_seq(100, 3), rotg(a, 5), 1'b0, 0, 0, 1'b0);

        // neighbour ties: south, east, west equal -> south; R1
        set_nbr(40, 25, 25, 25);
        run_gen("R4", rotg(cur_chrom, 3), rotg(cur_chrom, 7), 1'b0, 0, 0, 1'b0);
        // north ties east and west -> north; R1
        set_nbr(10, 30, 10, 10);
        run_gen("R4", rotg(cur_chrom, 11), swapg(cur_chrom, 4, 9), 1'b0, 0, 0, 1'b0);

        // survivor tie with parent: reversed children score the same -> parent kept
        run_gen("R4", revg(cur_chrom), revg(cur_chrom), 1'b0, 0, 0, 1'b0);

        // child one and child two tie below parent -> child one kept
        b = swapg(mk_seq(200, 5), 2, 20);
        do_load(b);
        run_gen("R4", mk_seq(200, 5), revg(mk_seq(200, 5)), 1'b0, 0, 0, 1'b0);

        // swap mutation on the survivor
        run_gen("R5", rotg(cur_chrom, 1), rotg(cur_chrom, 2), 1'b1, 3, 17, 1'b0);

        // equal positions leave survivor unchanged
        run_gen("R6", rotg(cur_chrom, 4), swapg(cur_chrom, 0, 5), 1'b1, 9, 9, 1'b0);

        // start and load during a generation are ignored
        set_nbr(60, 70, 15, 80);
        run_gen("R8", rotg(cur_chrom, 6), revg(cur_chrom), 1'b0, 0, 0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule